// File: doc/BRIEF.md
# Triple Row Buffer Manager

This block owns three row-sized byte stores and decides who may touch each one. A streaming writer pushes pixels one byte at a time into the buffer it has been given. A row consumer works on the most recently finished row and the row before it, which together feed a sliding 3x3 window. The block counts the bytes of each row itself. When a row is complete, it posts that buffer's number into a one-entry ready mailbox. The consumer empties the mailbox with an acknowledge pulse.

The buffer being filled is never the mailbox entry and never the consumer's current row. When the writer finishes a row it moves to the next buffer in modulo-3 order and skips any buffer that is still protected. When no buffer is free, it refills the buffer it just finished. A row that finishes while the mailbox is still occupied is dropped, the older entry stays in the mailbox, and a sticky overrun flag is raised. The consumer reads its two rows through a registered column-addressed port.

Top module: `triple_row_buf`

## Requirements
- R1: After a synchronous reset the writer buffer is 0, the mailbox reads 8'hFF (empty), neither held row is valid, overrun is 0 and row_done is 0.
- R2: A row completes on the ROW_LEN-th byte accepted with wr_valid high, counted from reset or from the previous completion. Cycles with wr_valid low do not count. row_done pulses high for exactly the one cycle after the completing byte.
- R3: When a row completes and the mailbox is empty, or is being acknowledged in the same cycle, rdy_idx holds the completed buffer's number (0, 1 or 2) in the cycle after.
- R4: On completion the next writer buffer is the first of (W+1) mod 3 and (W+2) mod 3 that is neither the updated mailbox entry nor the updated held current row. If neither candidate qualifies, the writer stays on W.
- R5: wr_buf_idx never equals a non-empty rdy_idx, and never equals cons_cur_idx while cons_cur_vld is high.
- R6: An acknowledge while the mailbox is full makes that entry the held current row. The old current row, with its valid bit, becomes the previous row. The mailbox becomes empty unless a row completes in the same cycle.
- R7: An acknowledge while the mailbox is empty has no effect on the held current and previous rows.
- R8: A row that completes while the mailbox is full and unacknowledged leaves the older entry in place. It sets overrun, which stays high until reset.
- R9: The byte accepted at position k of a row (k counted from 0) is stored at column k of the writer buffer. rd_cur_data and rd_prev_data return the byte at column rd_col of the held current and previous rows, one cycle after rd_col is presented.
- R10: rdy_idx only ever takes the values 0, 1, 2 or 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A pixel byte is offered this cycle |
| wr_data | input | PIX_W | Pixel byte |
| wr_buf_idx | output | 2 | Buffer currently being filled |
| row_done | output | 1 | One-cycle pulse after a row completes |
| rdy_idx | output | 8 | Ready mailbox: buffer number, or 8'hFF when empty |
| cons_ack | input | 1 | Consumer takes the mailbox entry |
| cons_cur_idx | output | 2 | Held current row buffer |
| cons_cur_vld | output | 1 | Held current row is valid |
| cons_prev_idx | output | 2 | Held previous row buffer |
| cons_prev_vld | output | 1 | Held previous row is valid |
| rd_col | input | clog2(ROW_LEN) | Column to read from both held rows |
| rd_cur_data | output | PIX_W | Byte of the current row, one cycle after rd_col |
| rd_prev_data | output | PIX_W | Byte of the previous row, one cycle after rd_col |
| overrun | output | 1 | Sticky: a completed row was dropped |

## Verification
A wrong column count shifts row_done and the mailbox post by at least one cycle. A bad rotation puts a protected buffer under the writer. Both show at the ports at the next completion. Corrupt buffer ownership appears as bytes from the wrong row on the read ports, within one cycle of a read of an affected column. A lost or spurious acknowledge is visible in the cycle after it, because the held indices either fail to change or change when they should not. The bench therefore compares every output against a behavioural model on every clock. The stimulus includes random gaps in the byte stream, acknowledges on an empty mailbox, acknowledges that coincide with a completion, and long runs with no acknowledge.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

    localparam int NBUF = 3;
    localparam int IDX_W = 2;
    localparam int MBOX_W = 8;
    localparam logic [MBOX_W-1:0] MBOX_EMPTY = 8'hFF;

    typedef logic [IDX_W-1:0] buf_idx_t;

    typedef struct packed {
        logic     vld;
        buf_idx_t idx;
    } slot_t;

    // (i + k) mod 3 for i in 0..2, k in 0..2
    function automatic buf_idx_t idx_step(buf_idx_t i, logic [1:0] k);
        logic [2:0] s;
        s = {1'b0, i} + {1'b0, k};
        if (s >= 3'(NBUF)) s = s - 3'(NBUF);
        return s[IDX_W-1:0];
    endfunction

    function automatic logic [MBOX_W-1:0] mbox_code(slot_t s);
        return s.vld ? {{(MBOX_W-IDX_W){1'b0}}, s.idx} : MBOX_EMPTY;
    endfunction

    function automatic logic slot_is(slot_t s, buf_idx_t i);
        return s.vld && (s.idx == i);
    endfunction

endpackage

// File: rtl/tbm_fill_ctrl.sv
module tbm_fill_ctrl #(
    parameter int ROW_LEN = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    output logic [$clog2(ROW_LEN)-1:0] col,
    output logic                       row_end
);
    localparam int COL_W = $clog2(ROW_LEN);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LEN - 1);

    logic [COL_W-1:0] col_q;

    assign col     = col_q;
    assign row_end = wr_valid && (col_q == LAST_COL);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
        end else if (wr_valid) begin
            col_q <= row_end ? '0 : col_q + 1'b1;
        end
    end

endmodule

// File: rtl/tbm_row_store.sv
module tbm_row_store
    import tbm_pkg::*;
#(
    parameter int ROW_LEN = 256,
    parameter int PIX_W   = 8
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  buf_idx_t                   wr_bank,
    input  logic [$clog2(ROW_LEN)-1:0] wr_col,
    input  logic [PIX_W-1:0]           wr_data,
    input  logic [$clog2(ROW_LEN)-1:0] rd_col,
    input  buf_idx_t                   rd_bank_a,
    input  buf_idx_t                   rd_bank_b,
    output logic [PIX_W-1:0]           rd_data_a,
    output logic [PIX_W-1:0]           rd_data_b
);
    logic [NBUF*PIX_W-1:0] bank_q;
    buf_idx_t              sel_a_q;
    buf_idx_t              sel_b_q;

    generate
        for (genvar b = 0; b < NBUF; b++) begin : g_bank
            logic [PIX_W-1:0] cells [ROW_LEN];
            logic [PIX_W-1:0] q;
            always_ff @(posedge clk) begin
                if (wr_en && (wr_bank == IDX_W'(b))) begin
                    cells[wr_col] <= wr_data;
                end
                q <= cells[rd_col];
            end
            assign bank_q[b*PIX_W +: PIX_W] = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        sel_a_q <= rd_bank_a;
        sel_b_q <= rd_bank_b;
    end

    always_comb begin
        rd_data_a = '0;
        rd_data_b = '0;
        for (int b = 0; b < NBUF; b++) begin
            if (sel_a_q == IDX_W'(b)) rd_data_a = bank_q[b*PIX_W +: PIX_W];
            if (sel_b_q == IDX_W'(b)) rd_data_b = bank_q[b*PIX_W +: PIX_W];
        end
    end

endmodule

// File: rtl/tbm_handoff.sv
module tbm_handoff
    import tbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     row_end,
    input  logic     cons_ack,
    output buf_idx_t wr_idx,
    output slot_t    mbox,
    output slot_t    cur,
    output slot_t    prev,
    output logic     overrun,
    output logic     row_done
);
    buf_idx_t wr_q,   wr_n;
    slot_t    mbox_q, mbox_n;
    slot_t    cur_q,  cur_n;
    slot_t    prev_q, prev_n;
    logic     ovr_q,  ovr_n;
    logic     done_q;
    logic     take;

    assign take = cons_ack && mbox_q.vld;

    always_comb begin
        cur_n  = cur_q;
        prev_n = prev_q;
        mbox_n = mbox_q;
        ovr_n  = ovr_q;
        wr_n   = wr_q;

        if (take) begin
            prev_n     = cur_q;
            cur_n.vld  = 1'b1;
            cur_n.idx  = mbox_q.idx;
            mbox_n.vld = 1'b0;
        end

        if (row_end) begin
            if (!mbox_n.vld) begin
                mbox_n.vld = 1'b1;
                mbox_n.idx = wr_q;
            end else begin
                ovr_n = 1'b1;
            end
            // farthest candidate first so the nearest free one wins
            for (int k = 2; k >= 1; k--) begin
                if (!slot_is(mbox_n, idx_step(wr_q, 2'(k))) &&
                    !slot_is(cur_n,  idx_step(wr_q, 2'(k)))) begin
                    wr_n = idx_step(wr_q, 2'(k));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            mbox_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
            ovr_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            wr_q   <= wr_n;
            mbox_q <= mbox_n;
            cur_q  <= cur_n;
            prev_q <= prev_n;
            ovr_q  <= ovr_n;
            done_q <= row_end;
        end
    end

    assign wr_idx   = wr_q;
    assign mbox     = mbox_q;
    assign cur      = cur_q;
    assign prev     = prev_q;
    assign overrun  = ovr_q;
    assign row_done = done_q;

endmodule

// File: rtl/triple_row_buf.sv
module triple_row_buf
    import tbm_pkg::*;
#(
    parameter int ROW_LEN = 256,
    parameter int PIX_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  logic [PIX_W-1:0]           wr_data,
    output logic [1:0]                 wr_buf_idx,
    output logic                       row_done,
    output logic [7:0]                 rdy_idx,
    input  logic                       cons_ack,
    output logic [1:0]                 cons_cur_idx,
    output logic                       cons_cur_vld,
    output logic [1:0]                 cons_prev_idx,
    output logic                       cons_prev_vld,
    input  logic [$clog2(ROW_LEN)-1:0] rd_col,
    output logic [PIX_W-1:0]           rd_cur_data,
    output logic [PIX_W-1:0]           rd_prev_data,
    output logic                       overrun
);
    localparam int COL_W = $clog2(ROW_LEN);

    logic [COL_W-1:0] fill_col;
    logic             row_end;
    buf_idx_t         wr_idx;
    slot_t            mbox, cur, prev;

    tbm_fill_ctrl #(.ROW_LEN(ROW_LEN)) u_fill (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .col      (fill_col),
        .row_end  (row_end)
    );

    tbm_handoff u_handoff (
        .clk      (clk),
        .rst      (rst),
        .row_end  (row_end),
        .cons_ack (cons_ack),
        .wr_idx   (wr_idx),
        .mbox     (mbox),
        .cur      (cur),
        .prev     (prev),
        .overrun  (overrun),
        .row_done (row_done)
    );

    tbm_row_store #(.ROW_LEN(ROW_LEN), .PIX_W(PIX_W)) u_store (
        .clk       (clk),
        .wr_en     (wr_valid),
        .wr_bank   (wr_idx),
        .wr_col    (fill_col),
        .wr_data   (wr_data),
        .rd_col    (rd_col),
        .rd_bank_a (cur.idx),
        .rd_bank_b (prev.idx),
        .rd_data_a (rd_cur_data),
        .rd_data_b (rd_prev_data)
    );

    assign wr_buf_idx    = wr_idx;
    assign rdy_idx       = mbox_code(mbox);
    assign cons_cur_idx  = cur.idx;
    assign cons_cur_vld  = cur.vld;
    assign cons_prev_idx = prev.idx;
    assign cons_prev_vld = prev.vld;

endmodule

// File: rtl/triple_row_buf_chk.sv
module triple_row_buf_chk #(
    parameter int ROW_LEN = 256
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] wr_buf_idx,
    input logic       row_done,
    input logic [7:0] rdy_idx,
    input logic       cons_ack,
    input logic [1:0] cons_cur_idx,
    input logic       cons_cur_vld,
    input logic [1:0] cons_prev_idx,
    input logic       cons_prev_vld,
    input logic       overrun
);
    p_wr_not_mbox_r5: assert property (@(posedge clk) disable iff (rst)
        (rdy_idx != 8'hFF) |-> (rdy_idx[1:0] != wr_buf_idx));

    p_wr_not_cur_r5: assert property (@(posedge clk) disable iff (rst)
        cons_cur_vld |-> (cons_cur_idx != wr_buf_idx));

    p_mbox_code_r10: assert property (@(posedge clk) disable iff (rst)
        (rdy_idx <= 8'd2) || (rdy_idx == 8'hFF));

    p_ack_take_r6: assert property (@(posedge clk) disable iff (rst)
        (cons_ack && rdy_idx != 8'hFF) |=>
            (cons_cur_vld && cons_cur_idx == $past(rdy_idx[1:0])));

    p_ack_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (cons_ack && rdy_idx == 8'hFF) |=>
            ($stable(cons_cur_idx) && $stable(cons_cur_vld) &&
             $stable(cons_prev_idx) && $stable(cons_prev_vld)));

    p_done_posts_r3: assert property (@(posedge clk) disable iff (rst)
        row_done |-> (rdy_idx != 8'hFF));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (row_done && ROW_LEN > 1) |=> !row_done);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_ovr_keep_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($past(rdy_idx) != 8'hFF && rdy_idx == $past(rdy_idx)));

endmodule

bind triple_row_buf triple_row_buf_chk #(.ROW_LEN(ROW_LEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_buf_idx    (wr_buf_idx),
    .row_done      (row_done),
    .rdy_idx       (rdy_idx),
    .cons_ack      (cons_ack),
    .cons_cur_idx  (cons_cur_idx),
    .cons_cur_vld  (cons_cur_vld),
    .cons_prev_idx (cons_prev_idx),
    .cons_prev_vld (cons_prev_vld),
    .overrun       (overrun)
);

// File: tb/triple_row_buf_bench.sv
module triple_row_buf_bench;
    localparam int RL  = 32;
    localparam int CW  = $clog2(RL);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    wr_buf_idx;
    logic          row_done;
    logic [7:0]    rdy_idx;
    logic          cons_ack = 1'b0;
    logic [1:0]    cons_cur_idx;
    logic          cons_cur_vld;
    logic [1:0]    cons_prev_idx;
    logic          cons_prev_vld;
    logic [CW-1:0] rd_col = '0;
    logic [7:0]    rd_cur_data;
    logic [7:0]    rd_prev_data;
    logic          overrun;

    always #5 clk = ~clk;

    triple_row_buf #(.ROW_LEN(RL), .PIX_W(8)) u_triple_row_buf (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_buf_idx(wr_buf_idx), .row_done(row_done), .rdy_idx(rdy_idx),
        .cons_ack(cons_ack), .cons_cur_idx(cons_cur_idx), .cons_cur_vld(cons_cur_vld),
        .cons_prev_idx(cons_prev_idx), .cons_prev_vld(cons_prev_vld),
        .rd_col(rd_col), .rd_cur_data(rd_cur_data), .rd_prev_data(rd_prev_data),
        .overrun(overrun)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // behavioural reference
    int m_wr, m_mb, m_cur, m_cur_v, m_prev, m_prev_v, m_ovr, m_col, m_done;
    int m_mem [3][RL];
    int exp_rc, exp_rp, exp_rc_v, exp_rp_v;
    string cur_tag = "R6";

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_wr = 0; m_mb = -1; m_cur = 0; m_cur_v = 0; m_prev = 0; m_prev_v = 0;
        m_ovr = 0; m_col = 0; m_done = 0; exp_rc_v = 0; exp_rp_v = 0;
    endtask

    task automatic model_step(input bit v, input int d, input bit a, input int c);
        bit end_row;
        int nw;
        exp_rc_v = m_cur_v;  exp_rc = m_mem[m_cur][c];
        exp_rp_v = m_prev_v; exp_rp = m_mem[m_prev][c];
        end_row = v && (m_col == RL - 1);
        if (v) begin
            m_mem[m_wr][m_col] = d;
            m_col = end_row ? 0 : m_col + 1;
        end
        cur_tag = (a && m_mb < 0) ? "R7" : "R6";
        if (a && m_mb >= 0) begin
            m_prev = m_cur; m_prev_v = m_cur_v;
            m_cur = m_mb; m_cur_v = 1; m_mb = -1;
        end
        m_done = end_row;
        if (end_row) begin
            if (m_mb < 0) m_mb = m_wr;
            else m_ovr = 1;
            nw = m_wr;
            for (int k = 1; k <= 2; k++) begin
                int cand;
                cand = (m_wr + k) % 3;
                if (nw == m_wr && cand != m_mb && !(m_cur_v && cand == m_cur)) nw = cand;
            end
            m_wr = nw;
        end
    endtask

    task automatic compare();
        chk("R4", "wr_buf_idx", int'(wr_buf_idx), m_wr);
        chk("R3", "rdy_idx", int'(rdy_idx), (m_mb < 0) ? 255 : m_mb);
        chk("R2", "row_done", int'(row_done), m_done);
        chk("R8", "overrun", int'(overrun), m_ovr);
        chk(cur_tag, "cons_cur_vld", int'(cons_cur_vld), m_cur_v);
        chk(cur_tag, "cons_prev_vld", int'(cons_prev_vld), m_prev_v);
        if (m_cur_v != 0)  chk(cur_tag, "cons_cur_idx", int'(cons_cur_idx), m_cur);
        if (m_prev_v != 0) chk(cur_tag, "cons_prev_idx", int'(cons_prev_idx), m_prev);
        if (exp_rc_v != 0) chk("R9", "rd_cur_data", int'(rd_cur_data), exp_rc);
        if (exp_rp_v != 0) chk("R9", "rd_prev_data", int'(rd_prev_data), exp_rp);
        if (rdy_idx != 8'hFF) chk("R5", "writer equals mailbox", int'(wr_buf_idx == rdy_idx[1:0]), 0);
        if (cons_cur_vld) chk("R5", "writer equals current", int'(wr_buf_idx == cons_cur_idx), 0);
        chk("R10", "mailbox code legal", int'(rdy_idx <= 8'd2 || rdy_idx == 8'hFF), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_valid = 1'b0; cons_ack = 1'b0;
        @(negedge clk);
        chk("R1", "reset wr_buf_idx", int'(wr_buf_idx), 0);
        chk("R1", "reset rdy_idx", int'(rdy_idx), 255);
        chk("R1", "reset cons_cur_vld", int'(cons_cur_vld), 0);
        chk("R1", "reset cons_prev_vld", int'(cons_prev_vld), 0);
        chk("R1", "reset overrun", int'(overrun), 0);
        chk("R1", "reset row_done", int'(row_done), 0);
        model_reset();
        rst = 1'b0;
        model_step(0, 0, 0, 0);
    endtask

    task automatic run(input int n, input int pv, input int pa);
        for (int i = 0; i < n; i++) begin
            bit v, a;
            int d, c;
            @(negedge clk);
            compare();
            v = ($urandom % 100) < pv;
            a = ($urandom % 100) < pa;
            d = int'($urandom % 256);
            c = int'($urandom % RL);
            wr_valid = v; wr_data = 8'(d); cons_ack = a; rd_col = CW'(c);
            model_step(v, d, a, c);
        end
    endtask

    initial begin
        for (int b = 0; b < 3; b++)
            for (int j = 0; j < RL; j++) m_mem[b][j] = 0;
        model_reset();
        do_reset();
        run(600, 100, 30);   // steady stream, frequent acks (R2 R3 R4 R6 R7 R9)
        run(300, 70, 0);     // no acks: overrun and stalled rotation (R8 R4)
        do_reset();          // overrun must clear (R1)
        run(3000, 80, 5);    // gappy stream, rare acks
        run(1500, 100, 50);  // ack and completion often coincide (R3 R6)
        @(negedge clk);
        compare();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule